// File: doc/BRIEF.md
# SD Card SPI-Mode Initialization Sequencer

This block takes a memory card from power-up to a ready state over an SPI-mode link. It owns chip select and talks to an external byte shifter through a one-byte exchange port. It pulses a start strobe with the byte to send, then waits for a done strobe that carries the byte received in the same transfer. The shifter, its clock rate (which must stay within 100 to 400 kHz during this phase) and all later data traffic are outside the block.

After a start request, the sequencer clocks out idle bytes with the card deselected, selects the card, and runs the command sequence: reset, interface check, OCR read, then repeated application init. Before every command it clocks out 0xFF until the card returns 0xFF. After every command it polls a bounded number of bytes for the R1 response. The illegal-command bit in R1 picks the path. A clear bit on the interface check means a version 2 card. A set bit there means a version 1 or legacy card. A set bit on application init means a legacy card, which is brought up with the legacy init command instead. The result is reported as ready plus a card-type code, or as an error plus the byte that caused it.

Top module: `sd_spi_init_seq`

## Requirements
- R1: After start, exactly WAKE_BYTES (10) exchanges of 0xFF go out with cs_no high. Every later exchange has cs_no low, and cs_no stays low once ready_o is set.
- R2: Command frames are sent as six bytes. Reset is 40 00 00 00 00 95. Interface check is 48 00 00 01 AA 87. OCR read is 7A 00 00 00 00 FD. Application prefix is 77 00 00 00 00 65. Application init is 69 40 10 00 00 CD on the version-2 path and 69 00 10 00 00 5F otherwise. Legacy init is 41 00 00 00 00 F9.
- R3: Before each command, 0xFF is sent until a received byte equals 0xFF. If PAD_MAX bytes in a row are not 0xFF, the block enters error and reports the last byte.
- R4: Only one exchange is outstanding at a time. xfer_start_o is a one-cycle pulse, and xfer_rx_i is used only in a cycle with xfer_done_i.
- R5: After a command, 0xFF is sent up to POLL_MAX (8) times. The first received byte with bit 7 clear is R1, and that includes the eighth. If none of the eight qualifies, the block enters error and reports the last byte.
- R6: Reset must answer R1 = 0x01. Any other R1 is an error that reports that R1.
- R7: If the interface-check R1 has bit 2 (illegal command, 0x04) set, the block takes the non-version-2 path and uses the standard-capacity init frame. An OCR-read R1 with bit 2 set is an error. Otherwise four OCR bytes follow, and ocr_o holds them with the first byte in bits 31:24.
- R8: An init R1 of 0x01 repeats the init (prefix plus application init, or legacy init). The RETRY_MAX-th consecutive 0x01 is an error that reports 0x01.
- R9: If application init answers with bit 2 set, the legacy init command is repeated until it answers 0x00. The retry count restarts at this switch.
- R10: On success ready_o rises and card_type_o is set: 3 for version 2, 2 for version 1, 1 for legacy, 0 before that. ready_o and error_o are never high together, and ready_o holds until the next start.
- R11: On error, cs_no goes high and err_r1_o holds the offending byte. start_i restarts the sequence from idle, ready or error, and is ignored while a sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin initialization |
| cs_no | output | 1 | Card chip select, active low |
| xfer_start_o | output | 1 | One-cycle request to exchange one byte |
| xfer_tx_o | output | 8 | Byte to send, valid with xfer_start_o |
| xfer_rx_i | input | 8 | Byte received, valid with xfer_done_i |
| xfer_done_i | input | 1 | Exchange complete |
| ready_o | output | 1 | Card initialized |
| card_type_o | output | 2 | 0 none, 1 legacy, 2 version 1, 3 version 2 |
| ocr_o | output | 32 | OCR collected after the OCR read |
| error_o | output | 1 | Sequence failed |
| err_r1_o | output | 8 | Byte that caused the failure |

## Verification
Two limits can be decided by the same done strobe. When the R1 answer arrives on the eighth poll byte, poll exhaustion and response acceptance fall in the same cycle. The bench provokes this with seven 0xFF fillers before a legacy-init R1 and checks that the sequence carries on. A case with eight 0xFF fillers checks that the same position becomes an error. The init retry count and the legacy switch meet in a similar way: an idle answer before the switch must not count against the retries after it. A reference card model in the bench checks every byte, its chip-select level and the final outputs.

// File: rtl/sd_init_pkg.sv
package sd_init_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAKE, S_PAD, S_CMD, S_POLL, S_OCR, S_DONE, S_ERR
  } seq_state_e;

  typedef enum logic [2:0] {
    C_RST, C_IFC, C_OCR, C_APP, C_INIT, C_MMC
  } cmd_e;

  localparam logic [1:0] T_NONE = 2'd0;
  localparam logic [1:0] T_MMC  = 2'd1;
  localparam logic [1:0] T_V1   = 2'd2;
  localparam logic [1:0] T_V2   = 2'd3;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;
  localparam int unsigned FRAME_BYTES = 6;
endpackage

// File: rtl/sd_cmd_frame.sv
module sd_cmd_frame
  import sd_init_pkg::*;
(
  input  cmd_e       cmd_i,
  input  logic       hc_i,
  input  logic [2:0] idx_i,
  output logic [7:0] byte_o
);
  logic [47:0] frame;
  logic [47:0] shifted;

  always_comb begin
    unique case (cmd_i)
      C_RST:   frame = 48'h40_00000000_95;
      C_IFC:   frame = 48'h48_000001AA_87;
      C_OCR:   frame = 48'h7A_00000000_FD;
      C_APP:   frame = 48'h77_00000000_65;
      C_INIT:  frame = hc_i ? 48'h69_40100000_CD : 48'h69_00100000_5F;
      C_MMC:   frame = 48'h41_00000000_F9;
      default: frame = 48'hFF_FFFFFFFF_FF;
    endcase
  end

  assign shifted = frame << {idx_i, 3'b000};
  assign byte_o  = shifted[47:40];
endmodule

// File: rtl/sd_retry_cnt.sv
module sd_retry_cnt #(
  parameter int unsigned MAX = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned W = (MAX < 2) ? 1 : $clog2(MAX + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == W'(MAX - 1));

  // R8: count never passes the limit, the owner stops incrementing at last
  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < W'(MAX));
  a_r8_no_inc_at_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !clr_i |-> !inc_i);
endmodule

// File: rtl/sd_spi_init_seq.sv
module sd_spi_init_seq
  import sd_init_pkg::*;
#(
  parameter int unsigned WAKE_BYTES = 10,
  parameter int unsigned POLL_MAX   = 8,
  parameter int unsigned PAD_MAX    = 64,
  parameter int unsigned RETRY_MAX  = 1000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic        cs_no,
  output logic        xfer_start_o,
  output logic [7:0]  xfer_tx_o,
  input  logic [7:0]  xfer_rx_i,
  input  logic        xfer_done_i,
  output logic        ready_o,
  output logic [1:0]  card_type_o,
  output logic [31:0] ocr_o,
  output logic        error_o,
  output logic [7:0]  err_r1_o
);
  localparam int unsigned M0 = (WAKE_BYTES > PAD_MAX) ? WAKE_BYTES : PAD_MAX;
  localparam int unsigned M1 = (M0 > POLL_MAX) ? M0 : POLL_MAX;
  localparam int unsigned CNT_MAX = (M1 > FRAME_BYTES) ? M1 : FRAME_BYTES;
  localparam int unsigned CW = $clog2(CNT_MAX + 1);

  seq_state_e  state_q, state_d;
  cmd_e        cmd_q, cmd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic        busy_q, busy_d;
  logic        cs_q, cs_d;
  logic        v1_q, v1_d;
  logic [31:0] ocr_q, ocr_d;
  logic [1:0]  type_q, type_d;
  logic [7:0]  errb_q, errb_d;
  logic        r_clr, r_inc, r_last;
  logic [7:0]  frame_byte;
  logic        sending;

  sd_cmd_frame u_frame (
    .cmd_i  (cmd_q),
    .hc_i   (!v1_q),
    .idx_i  (cnt_q[2:0]),
    .byte_o (frame_byte)
  );

  sd_retry_cnt #(.MAX(RETRY_MAX)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (r_clr),
    .inc_i  (r_inc),
    .last_o (r_last)
  );

  assign sending = (state_q == S_WAKE) || (state_q == S_PAD) || (state_q == S_CMD) ||
                   (state_q == S_POLL) || (state_q == S_OCR);
  assign xfer_start_o = sending && !busy_q;
  assign xfer_tx_o    = (state_q == S_CMD) ? frame_byte : IDLE_BYTE;
  assign cs_no        = cs_q;
  assign ready_o      = (state_q == S_DONE);
  assign error_o      = (state_q == S_ERR);
  assign card_type_o  = type_q;
  assign ocr_o        = ocr_q;
  assign err_r1_o     = errb_q;

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    cs_d    = cs_q;
    v1_d    = v1_q;
    ocr_d   = ocr_q;
    type_d  = type_q;
    errb_d  = errb_q;
    r_clr   = 1'b0;
    r_inc   = 1'b0;

    if (xfer_start_o) busy_d = 1'b1;

    if (state_q == S_IDLE || state_q == S_DONE || state_q == S_ERR) begin
      if (start_i) begin
        state_d = S_WAKE;
        cmd_d   = C_RST;
        cnt_d   = '0;
        cs_d    = 1'b1;
        v1_d    = 1'b0;
        type_d  = T_NONE;
        errb_d  = 8'h00;
        r_clr   = 1'b1;
      end
    end else if (busy_q && xfer_done_i) begin
      busy_d = 1'b0;
      unique case (state_q)
        S_WAKE: begin
          if (cnt_q == CW'(WAKE_BYTES - 1)) begin
            state_d = S_PAD;
            cnt_d   = '0;
            cs_d    = 1'b0;
          end else cnt_d = cnt_q + 1'b1;
        end
        S_PAD: begin
          if (xfer_rx_i == IDLE_BYTE) begin
            state_d = S_CMD;
            cnt_d   = '0;
          end else if (cnt_q == CW'(PAD_MAX - 1)) begin
            state_d = S_ERR;
            errb_d  = xfer_rx_i;
          end else cnt_d = cnt_q + 1'b1;
        end
        S_CMD: begin
          if (cnt_q == CW'(FRAME_BYTES - 1)) begin
            state_d = S_POLL;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        S_OCR: begin
          ocr_d = {ocr_q[23:0], xfer_rx_i};
          if (cnt_q == CW'(3)) begin
            state_d = S_PAD;
            cmd_d   = C_APP;
            cnt_d   = '0;
          end else cnt_d = cnt_q + 1'b1;
        end
        S_POLL: begin
          if (xfer_rx_i[7]) begin
            if (cnt_q == CW'(POLL_MAX - 1)) begin
              state_d = S_ERR;
              errb_d  = xfer_rx_i;
            end else cnt_d = cnt_q + 1'b1;
          end else begin
            // R1 decode; default is an error reporting this R1
            state_d = S_ERR;
            errb_d  = xfer_rx_i;
            cnt_d   = '0;
            unique case (cmd_q)
              C_RST: if (xfer_rx_i == 8'h01) begin
                state_d = S_PAD; cmd_d = C_IFC;
              end
              C_IFC: if ((xfer_rx_i & 8'hFA) == 8'h00) begin
                state_d = S_PAD; cmd_d = C_OCR; v1_d = xfer_rx_i[2];
              end
              C_OCR: if ((xfer_rx_i & 8'hFE) == 8'h00) begin
                state_d = S_OCR;
              end
              C_APP: if ((xfer_rx_i & 8'hFE) == 8'h00) begin
                state_d = S_PAD; cmd_d = C_INIT;
              end
              C_INIT, C_MMC: begin
                if (xfer_rx_i == 8'h00) begin
                  state_d = S_DONE;
                  type_d  = (cmd_q == C_MMC) ? T_MMC : (v1_q ? T_V1 : T_V2);
                end else if (xfer_rx_i == 8'h01) begin
                  if (!r_last) begin
                    state_d = S_PAD;
                    cmd_d   = (cmd_q == C_MMC) ? C_MMC : C_APP;
                    r_inc   = 1'b1;
                  end
                end else if (cmd_q == C_INIT && xfer_rx_i[2]) begin
                  state_d = S_PAD;
                  cmd_d   = C_MMC;
                  r_clr   = 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
        default: ;
      endcase
      if (state_d == S_ERR) cs_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cmd_q   <= C_RST;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      cs_q    <= 1'b1;
      v1_q    <= 1'b0;
      ocr_q   <= '0;
      type_q  <= T_NONE;
      errb_q  <= 8'h00;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      cs_q    <= cs_d;
      v1_q    <= v1_d;
      ocr_q   <= ocr_d;
      type_q  <= type_d;
      errb_q  <= errb_d;
    end
  end

  a_r4_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);
  a_r1_idle_while_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o && cs_no |-> xfer_tx_o == IDLE_BYTE);
  a_r2_frame_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o && state_q == S_CMD && cnt_q == '0 |-> xfer_tx_o[7:6] == 2'b01);
  a_r2_frame_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o && state_q == S_CMD && cnt_q == CW'(FRAME_BYTES - 1) |-> xfer_tx_o[0]);
  a_r10_ready_error_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && error_o));
  a_r10_ready_typed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> card_type_o != T_NONE);
  a_r10_ready_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !start_i |=> ready_o);
  a_r11_err_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> cs_no);
endmodule

// File: tb/sd_spi_init_seq_test.sv
module sd_spi_init_seq_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic cs_no, xfer_start_o, xfer_done_i, ready_o, error_o;
  logic [7:0] xfer_tx_o, xfer_rx_i, err_r1_o;
  logic [1:0] card_type_o;
  logic [31:0] ocr_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit running = 1'b0;

  localparam logic [47:0] F_RST = 48'h400000000095;
  localparam logic [47:0] F_IFC = 48'h48000001AA87;
  localparam logic [47:0] F_OCR = 48'h7A00000000FD;
  localparam logic [47:0] F_APP = 48'h770000000065;
  localparam logic [47:0] F_HC  = 48'h6940100000CD;
  localparam logic [47:0] F_SD  = 48'h69001000005F;
  localparam logic [47:0] F_MMC = 48'h4100000000F9;

  always #2.5 clk = ~clk;

  sd_spi_init_seq #(.WAKE_BYTES(10), .POLL_MAX(8), .PAD_MAX(8), .RETRY_MAX(3)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cs_no(cs_no),
    .xfer_start_o(xfer_start_o), .xfer_tx_o(xfer_tx_o), .xfer_rx_i(xfer_rx_i),
    .xfer_done_i(xfer_done_i), .ready_o(ready_o), .card_type_o(card_type_o),
    .ocr_o(ocr_o), .error_o(error_o), .err_r1_o(err_r1_o)
  );

  // reference card: expected host byte, chip-select level and reply per exchange
  logic [7:0] q_tx[$];
  logic       q_cs[$];
  logic [7:0] q_rp[$];
  string      q_tag[$];
  int         cdown = 0;
  logic [7:0] pend = 8'hFF;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic xb(logic [7:0] tx, logic cs, logic [7:0] rp, string tag);
    q_tx.push_back(tx); q_cs.push_back(cs); q_rp.push_back(rp); q_tag.push_back(tag);
  endtask

  task automatic wake();
    repeat (10) xb(8'hFF, 1'b1, 8'hFF, "R1");
  endtask

  task automatic cmd(logic [47:0] f, int npad, int fill, logic [7:0] r1);
    repeat (npad) xb(8'hFF, 1'b0, 8'h00, "R3");
    xb(8'hFF, 1'b0, 8'hFF, "R3");
    for (int i = 0; i < 6; i++) xb(8'(f >> (8 * (5 - i))), 1'b0, 8'hFF, "R2");
    repeat (fill) xb(8'hFF, 1'b0, 8'hFF, "R5");
    xb(8'hFF, 1'b0, r1, "R5");
  endtask

  task automatic ocr(logic [31:0] v);
    for (int i = 0; i < 4; i++) xb(8'hFF, 1'b0, 8'(v >> (8 * (3 - i))), "R7");
  endtask

  always @(negedge clk) begin
    if (xfer_done_i) xfer_done_i <= 1'b0;
    if (cdown > 0) begin
      cdown = cdown - 1;
      if (cdown == 0) begin
        xfer_done_i <= 1'b1;
        xfer_rx_i   <= pend;
      end
    end
    if (rst_ni && xfer_start_o) begin
      if (q_tx.size() == 0) begin
        check(1'b0, "R4", "unexpected exchange", xfer_tx_o, 0);
      end else begin
        string t;
        logic [7:0] et;
        logic ec;
        t = q_tag.pop_front();
        et = q_tx.pop_front();
        ec = q_cs.pop_front();
        check(xfer_tx_o == et, t, "tx byte", xfer_tx_o, et);
        check(cs_no == ec, (t == "R1") ? "R1" : "R1/cs", "chip select", cs_no, ec);
        check(cdown == 0, "R4", "overlapping exchange", cdown, 0);
        pend  = q_rp.pop_front();
        cdown = 2;
      end
    end
    if (running && q_tx.size() > 0 && (ready_o || error_o))
      check(1'b0, "R10", "finished early", q_tx.size(), 0);
  end

  task automatic run(bit poke);
    int n;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    running = 1'b1;
    if (poke) begin
      repeat (60) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
    end
    n = 0;
    while (!(ready_o || error_o) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    running = 1'b0;
    check(q_tx.size() == 0, "R4", "unconsumed exchanges", q_tx.size(), 0);
    q_tx.delete(); q_cs.delete(); q_rp.delete(); q_tag.delete();
  endtask

  task automatic expect_ready(logic [1:0] t, string tag);
    check(ready_o && !error_o, tag, "ready", {ready_o, error_o}, 2'b10);
    check(card_type_o == t, tag, "card type", card_type_o, t);
    check(cs_no == 1'b0, "R1", "cs held low after ready", cs_no, 0);
  endtask

  task automatic expect_error(logic [7:0] b, string tag);
    check(error_o && !ready_o, tag, "error", {ready_o, error_o}, 2'b01);
    check(err_r1_o == b, tag, "error byte", err_r1_o, b);
    check(cs_no == 1'b1, "R11", "cs released on error", cs_no, 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 150000) begin
        check(1'b0, "R4", "watchdog expired", cyc, 0);
        summary();
      end
    end
  end

  initial begin
    xfer_done_i = 1'b0;
    xfer_rx_i = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(cs_no == 1'b1 && !xfer_start_o, "R11", "reset idle outputs", {cs_no, xfer_start_o}, 2'b10);
    check(!ready_o && !error_o && card_type_o == 2'd0, "R10", "reset status",
          {ready_o, error_o, card_type_o}, 0);

    // version 2 card, one idle retry, R7 trailer bytes drained by padding (R8)
    wake();
    cmd(F_RST, 0, 2, 8'h01);
    cmd(F_IFC, 0, 0, 8'h01);
    cmd(F_OCR, 4, 0, 8'h01);
    ocr(32'hC0FF8000);
    cmd(F_APP, 0, 0, 8'h01);
    cmd(F_HC, 0, 1, 8'h01);
    cmd(F_APP, 0, 0, 8'h01);
    cmd(F_HC, 0, 0, 8'h00);
    run(1'b0);
    expect_ready(2'd3, "R10");
    check(ocr_o == 32'hC0FF8000, "R7", "ocr value", ocr_o, 32'hC0FF8000);

    // version 1 card; start_i mid-run must be ignored (R11)
    wake();
    cmd(F_RST, 0, 0, 8'h01);
    cmd(F_IFC, 0, 0, 8'h05);
    cmd(F_OCR, 0, 0, 8'h01);
    ocr(32'h00FF8000);
    cmd(F_APP, 0, 0, 8'h01);
    cmd(F_SD, 0, 0, 8'h00);
    run(1'b1);
    expect_ready(2'd2, "R7");
    check(ocr_o == 32'h00FF8000, "R7", "ocr value v1", ocr_o, 32'h00FF8000);

    // legacy card: retry count restarts at switch (R9), R1 on 8th poll byte (R5)
    wake();
    cmd(F_RST, 0, 0, 8'h01);
    cmd(F_IFC, 0, 0, 8'h05);
    cmd(F_OCR, 0, 0, 8'h01);
    ocr(32'h00FF8000);
    cmd(F_APP, 0, 0, 8'h01);
    cmd(F_SD, 0, 0, 8'h01);
    cmd(F_APP, 0, 0, 8'h01);
    cmd(F_SD, 0, 0, 8'h05);
    cmd(F_MMC, 0, 7, 8'h01);
    cmd(F_MMC, 0, 0, 8'h01);
    cmd(F_MMC, 0, 0, 8'h00);
    run(1'b0);
    expect_ready(2'd1, "R9");

    // no R1 within eight poll bytes (R5)
    wake();
    cmd(F_RST, 0, 7, 8'hFF);
    run(1'b0);
    expect_error(8'hFF, "R5");

    // reset answered not-idle (R6)
    wake();
    cmd(F_RST, 0, 0, 8'h00);
    run(1'b0);
    expect_error(8'h00, "R6");

    // OCR read illegal (R7)
    wake();
    cmd(F_RST, 0, 0, 8'h01);
    cmd(F_IFC, 0, 0, 8'h05);
    cmd(F_OCR, 0, 0, 8'h05);
    run(1'b0);
    expect_error(8'h05, "R7");

    // init stays idle RETRY_MAX times (R8)
    wake();
    cmd(F_RST, 0, 0, 8'h01);
    cmd(F_IFC, 0, 0, 8'h01);
    cmd(F_OCR, 0, 0, 8'h01);
    ocr(32'h40FF8000);
    for (int k = 0; k < 3; k++) begin
      cmd(F_APP, 0, 0, 8'h01);
      cmd(F_HC, 0, 0, 8'h01);
    end
    run(1'b0);
    expect_error(8'h01, "R8");

    // card never releases the line between commands (R3)
    wake();
    cmd(F_RST, 0, 0, 8'h01);
    repeat (8) xb(8'hFF, 1'b0, 8'h00, "R3");
    run(1'b0);
    expect_error(8'h00, "R3");

    summary();
  end
endmodule